// File: doc/BRIEF.md
# Two-Level Interrupt Cause Aggregator

This block gathers interrupt sources from two host-controller groups, each serving four ports, into one 32-bit main cause word. Every port raises an error event and a completion event. Each group also raises a coalesced-completion event. All of these are one-cycle pulses, and each sets a sticky bit in the main cause word. A port's bits stay set until that port's acknowledge input clears them. A group's coalesced bit stays set until that group's acknowledge input clears it.

A secondary bus-error cause register collects bus-error event pulses. It has its own mask. When any of its bits is both set and unmasked, a summary bit in the main cause word goes high. Software clears secondary bits by writing a word in which a 0 clears the matching bit and a 1 leaves it alone. So writing the inverse of the bits seen acknowledges exactly those bits.

A main mask register selects which main cause bits reach the single level interrupt output. A small register port has a 2-bit address and read data that follows the address combinationally. It gives read access to the main cause, read and write access to both masks, and write-zero-to-clear access to the secondary cause.

Top module: `irq_cause_agg`

## Requirements
- R1: An error pulse on port p of group g (input index 4*g+p) sets main cause bit 2*p+9*g. The bit stays set after the pulse ends.
- R2: A completion pulse on port p of group g sets main cause bit 2*p+9*g+1. The bit is sticky.
- R3: A coalesced-completion pulse for group g sets main cause bit 9*g+8. The group acknowledge for g clears that bit.
- R4: A port acknowledge clears both the error bit and the completion bit of that port. If an event and its acknowledge arrive in the same cycle, the event wins and the bit stays set.
- R5: The interrupt output is high exactly when some main cause bit is set in the same position as a set main mask bit. Source, mask and output all share one clock, so a masked event never raises the output.
- R6: Address 1 reads and writes the main mask. Bits 0 to 18 are writable one by one, so writing a word that differs in one bit changes only that bit. Bits 19 to 31 always read as zero.
- R7: Address 2 holds the 8-bit secondary cause, which bus-error pulses set. A write to address 2 clears each bit where the written value has a 0 and keeps each bit where it has a 1. A pulse arriving in the same cycle as the write sets its bit anyway.
- R8: Main cause bit 18 is high exactly when the secondary cause AND the secondary mask (address 3, 8 bits) is nonzero.
- R9: After reset the main cause, the main mask, the secondary cause, the secondary mask and the interrupt output are all zero.
- R10: Address 0 is read-only. Writes to it leave the main cause unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| port_err_i | input | 8 | Per-port error event pulses, index 4*group+port |
| port_done_i | input | 8 | Per-port completion event pulses |
| grp_coal_i | input | 2 | Per-group coalesced-completion pulses |
| port_ack_i | input | 8 | Per-port acknowledge, clears the error and completion bits |
| grp_ack_i | input | 2 | Per-group acknowledge, clears the coalesced bit |
| berr_evt_i | input | 8 | Bus-error event pulses into the secondary cause |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 cause, 1 mask, 2 secondary cause, 3 secondary mask |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| irq_o | output | 1 | Level interrupt output |

## Verification
A bit mapped to the wrong position shows up within one cycle of the event, as a wrong value when the cause word is read back. It can also show up as the interrupt output staying low under a mask that should pass the event. A stuck or leaking sticky bit is visible on the first read after an acknowledge. A clear that loses to an event shows the same way. A wrong write-zero-to-clear polarity in the secondary register appears in the secondary cause readback one cycle after the write, and it also appears at once on summary bit 18.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  typedef enum logic [1:0] {
    RA_CAUSE  = 2'd0,
    RA_MASK   = 2'd1,
    RA_SCAUSE = 2'd2,
    RA_SMASK  = 2'd3
  } reg_addr_e;

  // Bits occupied by the per-group event fields.
  function automatic logic [31:0] group_bits(int ng, int stride);
    logic [31:0] v;
    v = '0;
    for (int g = 0; g < ng; g++)
      for (int b = 0; b < stride; b++)
        v[g*stride+b] = 1'b1;
    return v;
  endfunction

  // Group fields plus the bus-error summary position.
  function automatic logic [31:0] live_bits(int ng, int stride, int sum_bit);
    logic [31:0] v;
    v = group_bits(ng, stride);
    v[sum_bit] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/irq_cause_map.sv
module irq_cause_map #(
  parameter int NG     = 2,
  parameter int NP     = 4,
  parameter int STRIDE = 9,
  parameter int DW     = 32
) (
  input  logic [NG*NP-1:0] err_i,
  input  logic [NG*NP-1:0] done_i,
  input  logic [NG-1:0]    coal_i,
  input  logic [NG*NP-1:0] ack_i,
  input  logic [NG-1:0]    gack_i,
  output logic [DW-1:0]    set_o,
  output logic [DW-1:0]    clr_o
);
  localparam int COAL_OFS = 2*NP;

  always_comb begin
    set_o = '0;
    clr_o = '0;
    for (int g = 0; g < NG; g++) begin
      for (int p = 0; p < NP; p++) begin
        set_o[2*p+STRIDE*g]   = err_i[g*NP+p];
        set_o[2*p+STRIDE*g+1] = done_i[g*NP+p];
        clr_o[2*p+STRIDE*g]   = ack_i[g*NP+p];
        clr_o[2*p+STRIDE*g+1] = ack_i[g*NP+p];
      end
      set_o[STRIDE*g+COAL_OFS] = coal_i[g];
      clr_o[STRIDE*g+COAL_OFS] = gack_i[g];
    end
  end
endmodule

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
  parameter int          DW    = 32,
  parameter logic [31:0] VALID = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] set_i,
  input  logic [DW-1:0] clr_i,
  output logic [DW-1:0] q_o
);
  logic [DW-1:0] q_d;
  logic          q_en;

  // Set has priority so an event coinciding with its clear is kept.
  always_comb begin
    q_en = (|set_i) | (|clr_i);
    q_d  = ((q_o & ~clr_i) | set_i) & VALID[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= '0;
    else if (q_en) q_o <= q_d;
  end
endmodule

// File: rtl/irq_sec_cause.sv
module irq_sec_cause #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         wr_cause_i,
  input  logic         wr_mask_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cause_o,
  output logic [W-1:0] mask_o,
  output logic         summary_o
);
  logic [W-1:0] cause_d;
  logic         cause_en;

  always_comb begin
    cause_en  = wr_cause_i | (|evt_i);
    cause_d   = (wr_cause_i ? (cause_o & wdata_i) : cause_o) | evt_i;
    summary_o = |(cause_o & mask_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cause_o <= '0;
    else if (cause_en) cause_o <= cause_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_o <= '0;
    else if (wr_mask_i) mask_o <= wdata_i;
  end
endmodule

// File: rtl/irq_cause_agg.sv
module irq_cause_agg
  import irq_agg_pkg::*;
#(
  parameter int NG      = 2,
  parameter int NP      = 4,
  parameter int STRIDE  = 9,
  parameter int SUM_BIT = 18,
  parameter int BERR_W  = 8,
  parameter int DW      = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NG*NP-1:0]     port_err_i,
  input  logic [NG*NP-1:0]     port_done_i,
  input  logic [NG-1:0]        grp_coal_i,
  input  logic [NG*NP-1:0]     port_ack_i,
  input  logic [NG-1:0]        grp_ack_i,
  input  logic [BERR_W-1:0]    berr_evt_i,
  input  logic                 reg_we_i,
  input  logic [1:0]           reg_addr_i,
  input  logic [DW-1:0]        reg_wdata_i,
  output logic [DW-1:0]        reg_rdata_o,
  output logic                 irq_o
);
  localparam logic [31:0] EVT_BITS  = group_bits(NG, STRIDE);
  localparam logic [31:0] LIVE_BITS = live_bits(NG, STRIDE, SUM_BIT);

  logic [1:0]        rst_pipe;
  logic              rst_n_sync;
  logic [DW-1:0]     set_vec, clr_vec, cause_q, cause_rd;
  logic [DW-1:0]     main_mask_q, main_mask_d;
  logic              main_mask_en;
  logic [BERR_W-1:0] sec_cause_q, sec_mask_q;
  logic              sec_summary;
  logic              wr_scause, wr_smask;

  // Reset asserts at once, releases after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe[1];

  irq_cause_map #(.NG(NG), .NP(NP), .STRIDE(STRIDE), .DW(DW)) u_map (
    .err_i  (port_err_i),
    .done_i (port_done_i),
    .coal_i (grp_coal_i),
    .ack_i  (port_ack_i),
    .gack_i (grp_ack_i),
    .set_o  (set_vec),
    .clr_o  (clr_vec)
  );

  irq_sticky_bank #(.DW(DW), .VALID(EVT_BITS)) u_bank (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .set_i (set_vec),
    .clr_i (clr_vec),
    .q_o   (cause_q)
  );

  always_comb begin
    wr_scause = reg_we_i && (reg_addr_e'(reg_addr_i) == RA_SCAUSE);
    wr_smask  = reg_we_i && (reg_addr_e'(reg_addr_i) == RA_SMASK);
  end

  irq_sec_cause #(.W(BERR_W)) u_sec (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .evt_i      (berr_evt_i),
    .wr_cause_i (wr_scause),
    .wr_mask_i  (wr_smask),
    .wdata_i    (reg_wdata_i[BERR_W-1:0]),
    .cause_o    (sec_cause_q),
    .mask_o     (sec_mask_q),
    .summary_o  (sec_summary)
  );

  // Main mask next state.
  always_comb begin
    main_mask_en = reg_we_i && (reg_addr_e'(reg_addr_i) == RA_MASK);
    main_mask_d  = reg_wdata_i & LIVE_BITS[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync)       main_mask_q <= '0;
    else if (main_mask_en) main_mask_q <= main_mask_d;
  end

  always_comb begin
    cause_rd          = cause_q;
    cause_rd[SUM_BIT] = sec_summary;
    irq_o             = |(cause_rd & main_mask_q);
    case (reg_addr_e'(reg_addr_i))
      RA_CAUSE:  reg_rdata_o = cause_rd;
      RA_MASK:   reg_rdata_o = main_mask_q;
      RA_SCAUSE: reg_rdata_o = DW'(sec_cause_q);
      default:   reg_rdata_o = DW'(sec_mask_q);
    endcase
  end
endmodule

// File: rtl/irq_cause_agg_chk.sv
module irq_cause_agg_chk #(
  parameter int          NG     = 2,
  parameter int          NP     = 4,
  parameter int          STRIDE = 9,
  parameter int          BERR_W = 8,
  parameter int          DW     = 32,
  parameter logic [31:0] LIVE   = '1
) (
  input logic              clk,
  input logic              rst_ns,
  input logic [NG*NP-1:0]  port_err_i,
  input logic [NG*NP-1:0]  port_done_i,
  input logic [NG-1:0]     grp_coal_i,
  input logic [NG*NP-1:0]  port_ack_i,
  input logic [NG-1:0]     grp_ack_i,
  input logic [BERR_W-1:0] berr_evt_i,
  input logic              reg_we_i,
  input logic [1:0]        reg_addr_i,
  input logic [BERR_W-1:0] wdata_lo,
  input logic [DW-1:0]     cause_q,
  input logic [DW-1:0]     mask_q,
  input logic [BERR_W-1:0] sec_cause_q,
  input logic              irq_o
);
  for (genvar g = 0; g < NG; g++) begin : g_grp
    for (genvar p = 0; p < NP; p++) begin : g_port
      localparam int EB = 2*p + STRIDE*g;

      // R1
      err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_ns)
        port_err_i[g*NP+p] |=> cause_q[EB]);

      // R4
      ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_ns)
        (port_ack_i[g*NP+p] && !port_err_i[g*NP+p] && !port_done_i[g*NP+p])
        |=> (!cause_q[EB] && !cause_q[EB+1]));
    end
  end

  // R6
  mask_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (mask_q & ~LIVE[DW-1:0]) == '0);

  // R5
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (mask_q == '0) |-> !irq_o);

  // R7
  w0c_clear_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (reg_we_i && reg_addr_i == 2'd2 && berr_evt_i == '0)
    |=> sec_cause_q == $past(sec_cause_q & wdata_lo));

  // R10
  cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (port_err_i == '0 && port_done_i == '0 && grp_coal_i == '0 &&
     port_ack_i == '0 && grp_ack_i == '0) |=> $stable(cause_q));
endmodule

bind irq_cause_agg irq_cause_agg_chk #(
  .NG(NG), .NP(NP), .STRIDE(STRIDE), .BERR_W(BERR_W), .DW(DW), .LIVE(LIVE_BITS)
) u_chk (
  .clk         (clk),
  .rst_ns      (rst_n_sync),
  .port_err_i  (port_err_i),
  .port_done_i (port_done_i),
  .grp_coal_i  (grp_coal_i),
  .port_ack_i  (port_ack_i),
  .grp_ack_i   (grp_ack_i),
  .berr_evt_i  (berr_evt_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .wdata_lo    (reg_wdata_i[BERR_W-1:0]),
  .cause_q     (cause_q),
  .mask_q      (main_mask_q),
  .sec_cause_q (sec_cause_q),
  .irq_o       (irq_o)
);

// File: tb/irq_cause_agg_tb.sv
`timescale 1ns/1ps
module irq_cause_agg_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  port_err, port_done, port_ack, berr_evt;
  logic [1:0]  grp_coal, grp_ack;
  logic        reg_we;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done_run = 1'b0;

  always #2.5 clk = ~clk;

  irq_cause_agg u_dut (
    .clk(clk), .rst_n(rst_n),
    .port_err_i(port_err), .port_done_i(port_done), .grp_coal_i(grp_coal),
    .port_ack_i(port_ack), .grp_ack_i(grp_ack), .berr_evt_i(berr_evt),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .irq_o(irq)
  );

  // {kind[1:0] (0 error, 1 completion, 2 coalesced), index[3:0], expected bit[4:0]}
  localparam logic [10:0] VEC [10] = '{
    {2'd0, 4'd0, 5'd0},  {2'd1, 4'd0, 5'd1},
    {2'd0, 4'd3, 5'd6},  {2'd1, 4'd3, 5'd7},
    {2'd0, 4'd4, 5'd9},  {2'd1, 4'd4, 5'd10},
    {2'd0, 4'd6, 5'd13}, {2'd1, 4'd7, 5'd16},
    {2'd2, 4'd0, 5'd8},  {2'd2, 4'd1, 5'd17}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic idle();
    port_err = '0; port_done = '0; port_ack = '0; berr_evt = '0;
    grp_coal = '0; grp_ack = '0; reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse(logic [7:0] e, logic [7:0] d, logic [1:0] c,
                       logic [7:0] a, logic [1:0] ga, logic [7:0] b);
    @(negedge clk);
    port_err = e; port_done = d; grp_coal = c;
    port_ack = a; grp_ack = ga; berr_evt = b;
    @(negedge clk);
    idle();
  endtask

  task automatic wr(logic [1:0] addr, logic [31:0] data);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = addr; reg_wdata = data;
    @(negedge clk);
    idle();
  endtask

  task automatic rd(logic [1:0] addr, output logic [31:0] data);
    @(negedge clk);
    reg_addr = addr;
    #1 data = reg_rdata;
  endtask

  initial begin
    #200000;
    if (!done_run) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    idle();
    reg_addr = 2'd0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 reset state
    rd(2'd0, v); check("R9 cause", v, 32'h0);
    rd(2'd1, v); check("R9 mask", v, 32'h0);
    rd(2'd2, v); check("R9 scause", v, 32'h0);
    rd(2'd3, v); check("R9 smask", v, 32'h0);
    check("R9 irq", {31'b0, irq}, 32'h0);

    // R5 masked event does not raise irq, cause still set
    pulse(8'h01, 8'h00, 2'b00, 8'h00, 2'b00, 8'h00);
    rd(2'd0, v); check("R1 masked set", v, 32'h1);
    check("R5 masked irq", {31'b0, irq}, 32'h0);
    pulse(8'h00, 8'h00, 2'b00, 8'h01, 2'b00, 8'h00);

    // R6 upper bits ignored
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, v); check("R6 mask upper", v, 32'h0007_FFFF);

    // Table walk: R1 R2 R3 R4 R5
    for (int i = 0; i < 10; i++) begin
      logic [1:0]  kind;
      logic [3:0]  idx;
      logic [4:0]  bitp;
      logic [7:0]  one8;
      logic [1:0]  one2;
      {kind, idx, bitp} = VEC[i];
      one8 = 8'h01 << idx;
      one2 = 2'b01 << idx[0];
      case (kind)
        2'd0:    pulse(one8, 8'h00, 2'b00, 8'h00, 2'b00, 8'h00);
        2'd1:    pulse(8'h00, one8, 2'b00, 8'h00, 2'b00, 8'h00);
        default: pulse(8'h00, 8'h00, one2, 8'h00, 2'b00, 8'h00);
      endcase
      rd(2'd0, v);
      check(kind == 2'd0 ? "R1 set" : (kind == 2'd1 ? "R2 set" : "R3 set"),
            v, 32'h1 << bitp);
      check("R5 irq high", {31'b0, irq}, 32'h1);
      if (kind == 2'd2) pulse(8'h00, 8'h00, 2'b00, 8'h00, one2, 8'h00);
      else              pulse(8'h00, 8'h00, 2'b00, one8, 2'b00, 8'h00);
      rd(2'd0, v);
      check(kind == 2'd2 ? "R3 clear" : "R4 clear", v, 32'h0);
      check("R5 irq low", {31'b0, irq}, 32'h0);
    end

    // R4 event wins over simultaneous ack
    pulse(8'h20, 8'h00, 2'b00, 8'h20, 2'b00, 8'h00);
    rd(2'd0, v); check("R4 event wins", v, 32'h1 << 11);

    // R10 write to cause is ignored
    wr(2'd0, 32'h0);
    rd(2'd0, v); check("R10 cause ro", v, 32'h1 << 11);
    pulse(8'h00, 8'h00, 2'b00, 8'h20, 2'b00, 8'h00);

    // R6 single-bit mask change (g1 p2 completion = bit 14)
    wr(2'd1, 32'h0007_BFFF);
    rd(2'd1, v); check("R6 single bit off", v, 32'h0007_BFFF);
    pulse(8'h00, 8'h40, 2'b00, 8'h00, 2'b00, 8'h00);
    check("R6 bit14 masked irq", {31'b0, irq}, 32'h0);
    wr(2'd1, 32'h0007_FFFF);
    check("R6 bit14 unmasked irq", {31'b0, irq}, 32'h1);
    pulse(8'h00, 8'h00, 2'b00, 8'h40, 2'b00, 8'h00);

    // R7 / R8 secondary cause
    pulse(8'h00, 8'h00, 2'b00, 8'h00, 2'b00, 8'h0F);
    rd(2'd2, v); check("R7 scause set", v, 32'h0F);
    rd(2'd0, v); check("R8 summary masked", v, 32'h0);
    wr(2'd3, 32'h01);
    rd(2'd0, v); check("R8 summary on", v, 32'h1 << 18);
    check("R8 irq", {31'b0, irq}, 32'h1);
    wr(2'd2, 32'hFFFF_FFFE);
    rd(2'd2, v); check("R7 w0c clear", v, 32'h0E);
    rd(2'd0, v); check("R8 summary off", v, 32'h0);
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, v); check("R7 w1 keeps", v, 32'h0E);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 32'h0; berr_evt = 8'h80;
    @(negedge clk);
    idle();
    rd(2'd2, v); check("R7 event wins", v, 32'h80);

    done_run = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule